// File: doc/BRIEF.md
# Block-Cipher Data-Port and Status Controller

This block sits between a 32-bit register bus and a 128-bit block-cipher core. Software or a DMA engine writes four 32-bit words into the data-input port. The block gathers them into one 128-bit block, starts the core and waits for its completion pulse. It then serves the 128-bit result back as four reads of the data-output port. A control register holds:

- the enable,
- the operating mode and the chaining mode,
- the interrupt enables,
- the DMA request enables,
- two self-clearing clear bits.

A status register reports completion, read errors and write errors.

Accesses to the data ports that arrive out of sequence are refused. They set sticky error flags and leave the buffers untouched. Key and IV words are writable at any time. They read back as zero while the unit is enabled. In counter chaining mode, the first IV word acts as a block counter that advances once per completed block. The cipher core is external and is reached through a start/done handshake with 128-bit data, key and IV buses.

Top module: `cipher_port_ctrl`

## Requirements
- R1: Four accepted writes to the input port (word address 2) form one block, with the first word in bits [127:96] and the last in bits [31:0]. The fourth write raises `core_start` for exactly one cycle and makes the unit busy until `core_done`.
- R2: `core_done` sets the complete flag (status bit 0). The next four reads of the output port (word address 3) return the result, most significant word first.
- R3: A read of the output port while no unread result word remains (before completion, or after all four have been read) sets the sticky read-error flag (status bit 1). It does not consume a word.
- R4: A write to the input port is refused if any of these holds: the unit is disabled (control bit 0 clear), a computation is busy, or result words remain unread. A refused write sets the sticky write-error flag (status bit 2) and leaves the input buffer unchanged.
- R5: Writing control bit 5 as one clears the complete flag. Writing control bit 6 as one clears both error flags. Both bits always read back as zero. A flag being set in the same cycle wins over its clear.
- R6: `irq_done` equals control bit 7 AND the complete flag. `irq_err` equals control bit 8 AND (read error OR write error).
- R7: With control bit 9 set, `dma_in_req` is high while all of these hold: the unit is enabled, it is not busy, and no result words are unread. With control bit 10 set, `dma_out_req` is high while the complete flag is set and result words remain unread.
- R8: When the operation field (control bits [2:1]) is 1 (key derivation), neither DMA request is ever asserted.
- R9: Key words (addresses 4 to 7) and IV words (addresses 8 to 11) read back as zero while the unit is enabled, and read back their stored value while it is disabled.
- R10: With the chaining field (control bits [4:3]) equal to 2 (counter mode), each completed block adds one to IV word 0 (bits [127:96] of the IV bus), wrapping modulo 2^32. IV words 1 to 3 stay unchanged.
- R11: The register map is: control at address 0, status at address 1. The control register reads back its stored fields.
- R12: After reset, every register and flag is zero, and no interrupt or DMA request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe; a read's side effects take place at the clock edge |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| core_start | output | 1 | One-cycle pulse that starts the core |
| core_din | output | 128 | Gathered input block |
| core_key | output | 128 | Key, word 0 in the top bits |
| core_iv | output | 128 | IV, word 0 (the counter) in the top bits |
| core_op | output | 2 | Operation field |
| core_chain | output | 2 | Chaining field |
| core_done | input | 1 | One-cycle completion pulse from the core |
| core_dout | input | 128 | Core result, valid with `core_done` |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |
| dma_in_req | output | 1 | Request for more input words |
| dma_out_req | output | 1 | Request to drain output words |

## Verification
The assertions assume that the core answers each `core_start` with exactly one `core_done` pulse, and that it never pulses `core_done` unprompted. They also assume that reset is held high before the first edge. The bench's core stub returns a single registered result a fixed three cycles after each start pulse. Stimulus strobes one register access per pair of cycles and always waits for the complete flag by polling the status register. A second start therefore never arrives while a block is still in flight.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = $clog2(BLK_WORDS + 1);

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
    localparam logic [ADDR_W-1:0] A_DIN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_DOUT = 4'd3;
    localparam logic [ADDR_W-1:0] A_KEY  = 4'd4;
    localparam logic [ADDR_W-1:0] A_IV   = 4'd8;

    localparam int B_EN     = 0;
    localparam int B_OP     = 1;
    localparam int B_CHAIN  = 3;
    localparam int B_CCFCLR = 5;
    localparam int B_ERRCLR = 6;
    localparam int B_CCIE   = 7;
    localparam int B_ERRIE  = 8;
    localparam int B_DMAIN  = 9;
    localparam int B_DMAOUT = 10;

    typedef enum logic [1:0] {
        OP_ENCRYPT = 2'd0, OP_KEYDERIVE = 2'd1,
        OP_DECRYPT = 2'd2, OP_DERIVE_DECRYPT = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        CH_ECB = 2'd0, CH_CBC = 2'd1, CH_CTR = 2'd2, CH_RSVD = 2'd3
    } chain_e;

    typedef struct packed {
        logic   dma_out_en;
        logic   dma_in_en;
        logic   err_ie;
        logic   cc_ie;
        chain_e chain;
        op_e    op;
        logic   enable;
    } ctrl_t;

    typedef struct packed {
        logic wrerr;
        logic rderr;
        logic ccf;
    } stat_t;

    function automatic ctrl_t ctrl_decode(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.enable     = w[B_EN];
        c.op         = op_e'(w[B_OP +: 2]);
        c.chain      = chain_e'(w[B_CHAIN +: 2]);
        c.cc_ie      = w[B_CCIE];
        c.err_ie     = w[B_ERRIE];
        c.dma_in_en  = w[B_DMAIN];
        c.dma_out_en = w[B_DMAOUT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_encode(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w               = '0;
        w[B_EN]         = c.enable;
        w[B_OP +: 2]    = c.op;
        w[B_CHAIN +: 2] = c.chain;
        w[B_CCIE]       = c.cc_ie;
        w[B_ERRIE]      = c.err_ie;
        w[B_DMAIN]      = c.dma_in_en;
        w[B_DMAOUT]     = c.dma_out_en;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] blk_word(input logic [BLK_W-1:0] b, input int idx);
        return b[BLK_W-1-idx*WORD_W -: WORD_W];
    endfunction
endpackage

// File: rtl/cpc_cfg_regs.sv
module cpc_cfg_regs
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ctr_step,
    output ctrl_t             ctrl,
    output logic              ccf_clr,
    output logic              err_clr,
    output logic [BLK_W-1:0]  key,
    output logic [BLK_W-1:0]  iv
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
    assign ccf_clr = ctrl_wr && wr_data[B_CCFCLR];
    assign err_clr = ctrl_wr && wr_data[B_ERRCLR];

    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (ctrl_wr) ctrl <= ctrl_decode(wr_data);
    end

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_word
        localparam logic [ADDR_W-1:0] KA = A_KEY + ADDR_W'(g);
        localparam logic [ADDR_W-1:0] VA = A_IV + ADDR_W'(g);
        logic [WORD_W-1:0] key_q;
        logic [WORD_W-1:0] iv_q;

        always_ff @(posedge clk) begin
            if (rst)                              key_q <= '0;
            else if (wr_en && (wr_addr == KA))    key_q <= wr_data;
        end

        if (g == 0) begin : g_ctr
            // word 0 doubles as the block counter in counter mode
            always_ff @(posedge clk) begin
                if (rst)                           iv_q <= '0;
                else if (wr_en && (wr_addr == VA)) iv_q <= wr_data;
                else if (ctr_step)                 iv_q <= iv_q + 1'b1;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)                           iv_q <= '0;
                else if (wr_en && (wr_addr == VA)) iv_q <= wr_data;
            end
        end

        assign key[BLK_W-1-g*WORD_W -: WORD_W] = key_q;
        assign iv[BLK_W-1-g*WORD_W -: WORD_W]  = iv_q;
    end
endmodule

// File: rtl/cpc_in_gather.sv
module cpc_in_gather
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] data,
    output logic              start,
    output logic [BLK_W-1:0]  block,
    output logic [CNT_W-1:0]  fill
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill  <= '0;
            start <= 1'b0;
            block <= '0;
        end else begin
            start <= 1'b0;
            if (push) begin
                for (int i = 0; i < BLK_WORDS; i++)
                    if (fill == CNT_W'(i))
                        block[BLK_W-1-i*WORD_W -: WORD_W] <= data;
                if (fill == LAST) begin
                    fill  <= '0;
                    start <= 1'b1;
                end else begin
                    fill <= fill + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cpc_out_serve.sv
module cpc_out_serve
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic              pop,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  remain
);
    logic [BLK_W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            remain <= '0;
        end else if (load) begin
            buf_q  <= blk_in;
            remain <= CNT_W'(BLK_WORDS);
        end else if (pop) begin
            buf_q  <= buf_q << WORD_W;
            remain <= remain - 1'b1;
        end
    end

    assign word = buf_q[BLK_W-1 -: WORD_W];
endmodule

// File: rtl/cipher_port_ctrl.sv
module cipher_port_ctrl
    import cpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              core_start,
    output logic [BLK_W-1:0]  core_din,
    output logic [BLK_W-1:0]  core_key,
    output logic [BLK_W-1:0]  core_iv,
    output logic [1:0]        core_op,
    output logic [1:0]        core_chain,
    input  logic              core_done,
    input  logic [BLK_W-1:0]  core_dout,
    output logic              irq_done,
    output logic              irq_err,
    output logic              dma_in_req,
    output logic              dma_out_req
);
    ctrl_t             ctrl;
    stat_t             stat;
    logic              ccf_clr, err_clr, busy;
    logic              din_wr, dout_rd, wr_bad, rd_bad, push, pop;
    logic [CNT_W-1:0]  in_fill, out_left;
    logic [WORD_W-1:0] out_word;

    assign din_wr  = wr_en && (wr_addr == A_DIN);
    assign dout_rd = rd_en && (rd_addr == A_DOUT);
    assign wr_bad  = din_wr && (!ctrl.enable || busy || (out_left != '0));
    assign rd_bad  = dout_rd && (out_left == '0);
    assign push    = din_wr && !wr_bad;
    assign pop     = dout_rd && !rd_bad;

    cpc_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctr_step(core_done && (ctrl.chain == CH_CTR)),
        .ctrl(ctrl), .ccf_clr(ccf_clr), .err_clr(err_clr), .key(core_key), .iv(core_iv)
    );

    cpc_in_gather u_in (
        .clk(clk), .rst(rst), .push(push), .data(wr_data),
        .start(core_start), .block(core_din), .fill(in_fill)
    );

    cpc_out_serve u_out (
        .clk(clk), .rst(rst), .load(core_done), .blk_in(core_dout), .pop(pop),
        .word(out_word), .remain(out_left)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            stat <= '0;
        end else begin
            if (push && (in_fill == CNT_W'(BLK_WORDS - 1))) busy <= 1'b1;
            else if (core_done)                            busy <= 1'b0;
            if (core_done)    stat.ccf <= 1'b1;
            else if (ccf_clr) stat.ccf <= 1'b0;
            if (rd_bad)       stat.rderr <= 1'b1;
            else if (err_clr) stat.rderr <= 1'b0;
            if (wr_bad)       stat.wrerr <= 1'b1;
            else if (err_clr) stat.wrerr <= 1'b0;
        end
    end

    assign core_op    = ctrl.op;
    assign core_chain = ctrl.chain;
    assign irq_done   = ctrl.cc_ie && stat.ccf;
    assign irq_err    = ctrl.err_ie && (stat.rderr || stat.wrerr);
    assign dma_in_req = ctrl.dma_in_en && ctrl.enable && (ctrl.op != OP_KEYDERIVE)
                        && !busy && (out_left == '0);
    assign dma_out_req = ctrl.dma_out_en && (ctrl.op != OP_KEYDERIVE)
                        && stat.ccf && (out_left != '0);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)      rd_data = ctrl_encode(ctrl);
        else if (rd_addr == A_STAT) rd_data = WORD_W'(stat);
        else if (rd_addr == A_DOUT) rd_data = out_word;
        else if (!ctrl.enable && (rd_addr[3:2] == A_KEY[3:2]))
            rd_data = blk_word(core_key, int'(rd_addr[1:0]));
        else if (!ctrl.enable && (rd_addr[3:2] == A_IV[3:2]))
            rd_data = blk_word(core_iv, int'(rd_addr[1:0]));
    end

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        core_start |-> busy);
    // R2
    done_load_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |=> (stat.ccf && out_left == CNT_W'(BLK_WORDS)));
    // R3
    rderr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_rd && out_left == '0) |=> (stat.rderr && $stable(out_left)));
    // R4
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (din_wr && busy) |=> (stat.wrerr && $stable(in_fill)));
    // R5
    rderr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.rderr && !err_clr) |=> stat.rderr);
    // R8
    kd_nodma_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.op == OP_KEYDERIVE) |-> !(dma_in_req || dma_out_req));
    // R9
    iv_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && rd_addr[3:2] == A_IV[3:2]) |-> (rd_data == '0));
endmodule

// File: tb/test_cipher_port_ctrl.sv
`timescale 1ns/1ps
module test_cipher_port_ctrl;
    import cpc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_data;
    logic              core_start, core_done;
    logic [BLK_W-1:0]  core_din, core_key, core_iv, core_dout;
    logic [1:0]        core_op, core_chain;
    logic              irq_done, irq_err, dma_in_req, dma_out_req;

    int vectors = 0;
    int fails   = 0;
    logic [WORD_W-1:0] exp_q[$];
    logic [WORD_W-1:0] key_m [BLK_WORDS];
    logic [WORD_W-1:0] iv_m  [BLK_WORDS];

    always #2.5 clk = ~clk;

    cipher_port_ctrl i_cipher_port_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .core_start(core_start), .core_din(core_din), .core_key(core_key), .core_iv(core_iv),
        .core_op(core_op), .core_chain(core_chain), .core_done(core_done), .core_dout(core_dout),
        .irq_done(irq_done), .irq_err(irq_err), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
    );

    // fixed-latency core stub
    logic [2:0] lat_sr;
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_sr    <= '0;
            core_dout <= '0;
        end else begin
            lat_sr <= {lat_sr[1:0], core_start};
            if (core_start) core_dout <= core_din ^ core_key ^ core_iv;
        end
    end
    assign core_done = lat_sr[2];

    task automatic check(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // driver: writes a block and pushes the expected result words
    task automatic send_block(input logic [BLK_W-1:0] blk);
        for (int i = 0; i < BLK_WORDS; i++)
            exp_q.push_back(blk_word(blk, i) ^ key_m[i] ^ iv_m[i]);
        for (int i = 0; i < BLK_WORDS; i++)
            wr(A_DIN, blk_word(blk, i));
    endtask

    task automatic wait_done();
        logic [WORD_W-1:0] s;
        for (int i = 0; i < 50; i++) begin
            rd(A_STAT, s);
            if (s[0]) break;
        end
    endtask

    // monitor side: reads output words and compares against the queue
    task automatic drain(input string req);
        logic [WORD_W-1:0] d;
        for (int i = 0; i < BLK_WORDS; i++) begin
            rd(A_DOUT, d);
            if (exp_q.size() == 0) check({req, " queue empty"}, d, 32'hx);
            else check(req, d, exp_q.pop_front());
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired");
        fails++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] cfg;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(A_STAT, d); check("R12 status", d, 0);
        rd(A_CTRL, d); check("R12 ctrl", d, 0);
        check("R12 outputs", {28'd0, irq_done, irq_err, dma_in_req, dma_out_req}, 0);

        for (int i = 0; i < BLK_WORDS; i++) begin
            key_m[i] = 32'h1000_0001 * (i + 3);
            iv_m[i]  = 32'h0A0B_0C00 + i;
            wr(A_KEY + ADDR_W'(i), key_m[i]);
            wr(A_IV + ADDR_W'(i), iv_m[i]);
        end
        // R9 readback while disabled
        rd(A_KEY + 4'd2, d); check("R9 key2 disabled", d, key_m[2]);
        rd(A_IV + 4'd3, d);  check("R9 iv3 disabled", d, iv_m[3]);

        // enable, CBC, both irqs, both dma
        cfg = 32'h789;
        wr(A_CTRL, cfg);
        rd(A_CTRL, d); check("R11 ctrl readback", d, cfg);
        check("R7 dma_in idle", dma_in_req, 1);
        rd(A_KEY, d); check("R9 key0 enabled", d, 0);
        rd(A_IV, d);  check("R9 iv0 enabled", d, 0);

        send_block(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        check("R1 dma_in busy", dma_in_req, 0);
        wr(A_DIN, 32'hDEAD_BEEF);  // while busy
        rd(A_STAT, d); check("R4 wrerr while busy", d & 32'h4, 32'h4);
        check("R6 irq_err", irq_err, 1);
        wait_done();
        rd(A_STAT, d); check("R2 ccf set", d, 32'h5);
        check("R6 irq_done", irq_done, 1);
        check("R7 dma_out", dma_out_req, 1);
        wr(A_CTRL, cfg | 32'h40);
        rd(A_STAT, d); check("R5 errors cleared", d, 32'h1);
        rd(A_CTRL, d); check("R5 clear bits read zero", d, cfg);
        check("R6 irq_err low", irq_err, 0);
        wr(A_DIN, 32'h1111_2222);  // output pending
        rd(A_STAT, d); check("R4 wrerr pending output", d, 32'h5);
        wr(A_CTRL, cfg | 32'h40);
        drain("R2 result A");
        check("R7 dma_out drained", dma_out_req, 0);
        check("R7 dma_in drained", dma_in_req, 1);
        rd(A_DOUT, d);
        rd(A_STAT, d); check("R3 extra read", d, 32'h3);
        wr(A_CTRL, cfg | 32'h20);
        rd(A_STAT, d); check("R5 ccf cleared", d, 32'h2);
        check("R6 irq_done low", irq_done, 0);
        wr(A_CTRL, cfg | 32'h40);
        rd(A_DOUT, d);
        rd(A_STAT, d); check("R3 read before completion", d, 32'h2);
        wr(A_CTRL, cfg | 32'h40);

        // second block checks buffers were left untouched by refused accesses
        send_block(128'hCAFE_0000_0000_FACE_5555_AAAA_0F0F_F0F0);
        wait_done();
        drain("R4 result B after refused accesses");
        wr(A_CTRL, cfg | 32'h20);

        // R8 key derivation
        cfg = 32'h789 | 32'h2;
        wr(A_CTRL, cfg);
        check("R8 no dma_in", dma_in_req, 0);
        send_block(128'h1);
        wait_done();
        check("R8 no dma_out", dma_out_req, 0);
        check("R2 core_op", {30'd0, core_op}, 1);
        drain("R8 result");
        wr(A_CTRL, cfg | 32'h20);

        // R10 counter mode with wrap
        wr(A_CTRL, 32'h0);
        iv_m[0] = 32'hFFFF_FFFF;
        wr(A_IV, iv_m[0]);
        wr(A_CTRL, 32'h11);
        send_block(128'h2222_3333_4444_5555_6666_7777_8888_9999);
        wait_done();
        check("R6 irq_done gated", irq_done, 0);
        drain("R10 counter result");
        wr(A_CTRL, 32'h0);
        rd(A_IV, d);        check("R10 counter wrapped", d, 32'h0);
        rd(A_IV + 4'd1, d); check("R10 nonce kept", d, iv_m[1]);

        // R4 disabled write
        wr(A_CTRL, 32'h20);
        wr(A_DIN, 32'h7);
        rd(A_STAT, d); check("R4 wrerr disabled", d, 32'h4);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule